// File: doc/BRIEF.md
# Lookahead-Pipelined First-Order Low-Pass Recursive Filter

This block smooths a stream of signed fixed-point samples with a single-pole low-pass response, y(n) = a·y(n-1) + (1-a)·x(n). It is meant for clock rates near 300 MHz at moderate word widths. At those rates a single-cycle feedback multiply-add would not close timing. The recursion is therefore unrolled by one step: y(n) = a²·y(n-2) + a(1-a)·x(n-1) + (1-a)·x(n). The loop now spans two clock periods, so its multiplier can carry a pipeline register. The two input terms do not depend on the output, and they are formed in a feed-forward pipeline ahead of the loop.

The pole value is fixed when the block is elaborated. It is given as an integer numerator `ALPHA_NUM` over 2^`COEF_FRAC`. All three derived coefficients are computed as constants at elaboration. A sample enters on every clock. A cycle without a valid input is treated as a zero sample, and the recursion still steps. The output strobe is the input strobe delayed by the pipeline latency.

Top module: `iir_la_lowpass`

## Requirements
- R1: With defaults (DATA_W=16, COEF_FRAC=16, ALPHA_NUM=60000), every output stays within 4 LSB of the ideal real-valued one-step recursion y(n) = a·y(n-1) + (1-a)·x(n), with a = ALPHA_NUM/2^COEF_FRAC and y(-1) = 0.
- R2: Every output is bit-exact to y(n) = clamp(floor((A²·y(n-2) + A·(2^C−A)·x(n−1) + (2^C−A)·2^C·x(n) + 2^(2C−1)) / 2^(2C))). Here A = ALPHA_NUM, C = COEF_FRAC, clamp limits to the signed DATA_W range, and y(-1), y(-2) and x(-1) are zero after reset.
- R3: out_valid equals in_valid delayed by LATENCY = 4 cycles (3 + PROD_REG). The out_data value that goes with an out_valid pulse is the result for the sample that was presented LATENCY cycles earlier.
- R4: In a cycle with in_valid low, in_data is ignored. That cycle enters the recursion as a zero sample.
- R5: With a full-scale input held (+max or −min of the signed range), the output settles to within 4 LSB of the input and keeps the input's sign. It never wraps past the range.
- R6: Synchronous reset clears all pipeline and loop state. During reset and after its release, out_valid and out_data are zero until a nonzero valid sample has passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output sample strobe, in_valid delayed by LATENCY |
| out_data | output | DATA_W | Signed filtered sample |

## Verification
A corrupted loop register shows up at out_data within one or two cycles of the fault. It then stays visible, decaying by only a² every two samples. A per-cycle bit-exact comparison therefore catches it long before it fades. A misaligned feed-forward tap or coefficient breaks the exact match on the first nonzero sample, for example an impulse. A wrong strobe delay shows on out_valid as soon as the first valid sample leaves the pipeline. The comparison is made against a behavioural model of the lookahead recursion and, with a small tolerance, against the ideal one-step recursion.

// File: rtl/iir_la_pkg.sv
`timescale 1ns/1ps
package iir_la_pkg;

   // weight of x(n), scaled to 2^(2*frac)
   function automatic longint la_cur_coef(input int alpha, input int frac);
      return ((longint'(1) << frac) - longint'(alpha)) << frac;
   endfunction

   // weight of x(n-1): a*(1-a), scaled to 2^(2*frac)
   function automatic longint la_prev_coef(input int alpha, input int frac);
      return longint'(alpha) * ((longint'(1) << frac) - longint'(alpha));
   endfunction

   // weight of y(n-2): a^2, scaled to 2^(2*frac)
   function automatic longint la_fb_coef(input int alpha);
      return longint'(alpha) * longint'(alpha);
   endfunction

endpackage

// File: rtl/iir_la_vpipe.sv
`timescale 1ns/1ps
module iir_la_vpipe #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (LEN == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= d;
         end
      end else begin : g_chain
         logic [LEN-1:0] sr;
         always_ff @(posedge clk) begin
            if (rst) sr <= '0;
            else     sr <= {sr[LEN-2:0], d};
         end
         assign q = sr[LEN-1];
      end
   endgenerate
endmodule

// File: rtl/iir_la_feedfwd.sv
`timescale 1ns/1ps
module iir_la_feedfwd #(
   parameter int DATA_W = 16,
   parameter int CW = 34,
   parameter bit PROD_REG = 1'b1,
   parameter logic signed [CW-1:0] K_CUR = '0,
   parameter logic signed [CW-1:0] K_PREV = '0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic signed [DATA_W-1:0]   in_data,
   output logic signed [DATA_W+CW:0]  ff_sum
);
   localparam int PW = DATA_W + CW;

   logic signed [DATA_W-1:0] x_cur, x_prev;
   logic signed [PW-1:0]     p_cur_c, p_prev_c, p_cur, p_prev;

   // stage 1: gated sample and its one-cycle-old neighbour
   always_ff @(posedge clk) begin
      if (rst) begin
         x_cur  <= '0;
         x_prev <= '0;
      end else begin
         x_prev <= x_cur;
         x_cur  <= in_valid ? in_data : '0;
      end
   end

   assign p_cur_c  = PW'(x_cur)  * PW'(K_CUR);
   assign p_prev_c = PW'(x_prev) * PW'(K_PREV);

   // stage 2 (optional): product register
   generate
      if (PROD_REG) begin : g_prod_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               p_cur  <= '0;
               p_prev <= '0;
            end else begin
               p_cur  <= p_cur_c;
               p_prev <= p_prev_c;
            end
         end
      end else begin : g_prod_comb
         assign p_cur  = p_cur_c;
         assign p_prev = p_prev_c;
      end
   endgenerate

   // last stage: registered sum handed to the loop
   always_ff @(posedge clk) begin
      if (rst) ff_sum <= '0;
      else     ff_sum <= (PW+1)'(p_cur) + (PW+1)'(p_prev);
   end
endmodule

// File: rtl/iir_la_loop.sv
`timescale 1ns/1ps
module iir_la_loop #(
   parameter int DATA_W = 16,
   parameter int CW = 34,
   parameter int COEF_FRAC = 16,
   parameter bit ROUND_NEAR = 1'b1,
   parameter logic signed [CW-1:0] K_FB = '0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic signed [DATA_W+CW:0]  ff_sum,
   output logic signed [DATA_W-1:0]   y
);
   localparam int PW    = DATA_W + CW;
   localparam int SW    = PW + 2;
   localparam int SHIFT = 2 * COEF_FRAC;
   localparam int RW    = SW - SHIFT;
   localparam logic signed [DATA_W-1:0] Y_TOP = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic signed [DATA_W-1:0] Y_BOT = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic signed [RW-1:0]     R_TOP = RW'(Y_TOP);
   localparam logic signed [RW-1:0]     R_BOT = RW'(Y_BOT);

   logic signed [PW-1:0]     fb_prod_r;   // second loop register
   logic signed [SW-1:0]     acc, biased, shifted;
   logic signed [RW-1:0]     scaled;
   logic signed [DATA_W-1:0] y_next;

   always_comb acc = SW'(ff_sum) + SW'(fb_prod_r);

   generate
      if (ROUND_NEAR) begin : g_round_near
         localparam logic signed [SW-1:0] HALF = SW'(longint'(1) << (SHIFT-1));
         always_comb biased = acc + HALF;
      end else begin : g_round_trunc
         always_comb biased = acc;
      end
   endgenerate

   always_comb begin
      shifted = biased >>> SHIFT;
      scaled  = shifted[RW-1:0];
      if (scaled > R_TOP)      y_next = Y_TOP;
      else if (scaled < R_BOT) y_next = Y_BOT;
      else                     y_next = scaled[DATA_W-1:0];
   end

   // y and fb_prod_r are the two registers closing the recursion
   always_ff @(posedge clk) begin
      if (rst) begin
         y         <= '0;
         fb_prod_r <= '0;
      end else begin
         y         <= y_next;
         fb_prod_r <= PW'(y) * PW'(K_FB);
      end
   end
endmodule

// File: rtl/iir_la_lowpass.sv
`timescale 1ns/1ps
module iir_la_lowpass #(
   parameter int DATA_W     = 16,
   parameter int COEF_FRAC  = 16,
   parameter int ALPHA_NUM  = 60000,
   parameter bit PROD_REG   = 1'b1,
   parameter bit ROUND_NEAR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_data
);
   localparam int CW      = 2 * COEF_FRAC + 2;
   localparam int PW      = DATA_W + CW;
   localparam int LATENCY = 3 + int'(PROD_REG);
   localparam logic signed [CW-1:0] K_CUR  = CW'(iir_la_pkg::la_cur_coef(ALPHA_NUM, COEF_FRAC));
   localparam logic signed [CW-1:0] K_PREV = CW'(iir_la_pkg::la_prev_coef(ALPHA_NUM, COEF_FRAC));
   localparam logic signed [CW-1:0] K_FB   = CW'(iir_la_pkg::la_fb_coef(ALPHA_NUM));

   generate
      if (DATA_W < 4 || DATA_W > 24) begin : g_bad_width
         $error("iir_la_lowpass: DATA_W must lie in 4..24");
      end
      if (COEF_FRAC < 4 || COEF_FRAC > 24) begin : g_bad_frac
         $error("iir_la_lowpass: COEF_FRAC must lie in 4..24");
      end
      if (ALPHA_NUM <= 0 || longint'(ALPHA_NUM) >= (longint'(1) << COEF_FRAC)) begin : g_bad_alpha
         $error("iir_la_lowpass: ALPHA_NUM must be in 1..2^COEF_FRAC-1");
      end
   endgenerate

   logic signed [PW:0] ff_sum;

   iir_la_feedfwd #(
      .DATA_W(DATA_W), .CW(CW), .PROD_REG(PROD_REG),
      .K_CUR(K_CUR), .K_PREV(K_PREV)
   ) u_ff (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .ff_sum(ff_sum)
   );

   iir_la_loop #(
      .DATA_W(DATA_W), .CW(CW), .COEF_FRAC(COEF_FRAC),
      .ROUND_NEAR(ROUND_NEAR), .K_FB(K_FB)
   ) u_loop (
      .clk(clk), .rst(rst), .ff_sum(ff_sum), .y(out_data)
   );

   iir_la_vpipe #(.LEN(LATENCY)) u_vld (
      .clk(clk), .rst(rst), .d(in_valid), .q(out_valid)
   );
endmodule

// File: rtl/iir_la_lowpass_chk.sv
`timescale 1ns/1ps
module iir_la_lowpass_chk #(
   parameter int DATA_W    = 16,
   parameter int COEF_FRAC = 16,
   parameter int ALPHA_NUM = 60000,
   parameter int LATENCY   = 4
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic signed [DATA_W-1:0] in_data,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] out_data
);
   localparam int SLEW = int'((((longint'(1) << COEF_FRAC) - longint'(ALPHA_NUM)) << DATA_W) >> COEF_FRAC) + 8;

   int unsigned              since_rst;
   logic                     seen_nz;
   logic [DATA_W:0]          peak, in_mag, out_mag;
   logic signed [DATA_W:0]   in_ext, out_ext;
   logic signed [DATA_W-1:0] prev_out;
   int                       step_diff;

   always_comb begin
      in_ext    = (DATA_W+1)'(in_data);
      out_ext   = (DATA_W+1)'(out_data);
      in_mag    = (in_ext  < 0) ? -in_ext  : in_ext;
      out_mag   = (out_ext < 0) ? -out_ext : out_ext;
      step_diff = int'(out_data) - int'(prev_out);
      if (step_diff < 0) step_diff = -step_diff;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= 0;
         seen_nz   <= 1'b0;
         peak      <= '0;
         prev_out  <= '0;
      end else begin
         if (since_rst < LATENCY) since_rst <= since_rst + 1;
         if (in_valid && in_data != '0) seen_nz <= 1'b1;
         if (in_valid && in_mag > peak) peak <= in_mag;
         prev_out <= out_data;
      end
   end

   // R3: strobe is the input strobe delayed by LATENCY
   a_r3_valid_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst == LATENCY) |-> (out_valid == $past(in_valid, LATENCY)));

   // R6: no nonzero valid input since reset means zero output
   a_r6_quiet_zero: assert property (@(posedge clk) disable iff (rst)
      !seen_nz |-> (out_data == '0));

   // R1: output magnitude never exceeds the largest input seen (plus one LSB)
   a_r1_bounded: assert property (@(posedge clk) disable iff (rst)
      out_mag <= peak + 1'b1);

   // R1: per-sample change limited by (1-a) times the full input span
   a_r1_slew: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 1) |-> (step_diff <= SLEW));
endmodule

bind iir_la_lowpass iir_la_lowpass_chk #(
   .DATA_W(DATA_W), .COEF_FRAC(COEF_FRAC), .ALPHA_NUM(ALPHA_NUM), .LATENCY(LATENCY)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
   .out_valid(out_valid), .out_data(out_data)
);

// File: tb/iir_la_lowpass_tb_top.sv
`timescale 1ns/1ps
module iir_la_lowpass_tb_top;
   localparam int  DW  = 16;
   localparam int  CF  = 16;
   localparam int  AN  = 60000;
   localparam int  LAT = 4;
   localparam longint KC  = ((longint'(1) << CF) - longint'(AN)) << CF;
   localparam longint KP  = longint'(AN) * ((longint'(1) << CF) - longint'(AN));
   localparam longint KA2 = longint'(AN) * longint'(AN);
   localparam longint YMAX = (longint'(1) << (DW-1)) - 1;
   localparam longint YMIN = -(longint'(1) << (DW-1));
   localparam real    ALPHA = real'(AN) / real'(longint'(1) << CF);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic iv  = 1'b0;
   logic signed [DW-1:0] id = '0;
   logic ov;
   logic signed [DW-1:0] od;
   logic signed [DW-1:0] rnd;

   always #2.5 clk = ~clk;

   iir_la_lowpass #(
      .DATA_W(DW), .COEF_FRAC(CF), .ALPHA_NUM(AN), .PROD_REG(1'b1), .ROUND_NEAR(1'b1)
   ) dut_i (
      .clk(clk), .rst(rst), .in_valid(iv), .in_data(id), .out_valid(ov), .out_data(od)
   );

   int     errs   = 0;
   int     checks = 0;
   bit     done   = 1'b0;
   longint xs[$];
   longint ys[$];
   real    yrs[$];
   bit     vs[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural models: lookahead form (bit-exact) and ideal one-step form (real)
   task automatic push_sample(input bit v, input longint d);
      longint xe, x1, y2, s, y;
      real    r1;
      xe = v ? d : 0;
      x1 = (xs.size() > 0) ? xs[xs.size()-1] : 0;
      y2 = (ys.size() > 1) ? ys[ys.size()-2] : 0;
      s  = KA2 * y2 + KP * x1 + KC * xe + (longint'(1) << (2*CF-1));
      y  = s >>> (2*CF);
      if (y > YMAX) y = YMAX;
      if (y < YMIN) y = YMIN;
      r1 = (yrs.size() > 0) ? yrs[yrs.size()-1] : 0.0;
      yrs.push_back(ALPHA * r1 + (1.0 - ALPHA) * real'(xe));
      xs.push_back(xe);
      ys.push_back(y);
      vs.push_back(v);
   endtask

   task automatic compare_out();
      int  idx;
      real dif;
      idx = xs.size() - LAT;
      if (idx < 0) begin
         check(ov == 1'b0, "R3", "out_valid before first result", longint'(ov), 0);
         check(od == '0, "R6", "out_data before first result", longint'(od), 0);
      end else begin
         check(ov == vs[idx], "R3", "out_valid alignment", longint'(ov), longint'(vs[idx]));
         check(longint'(od) == ys[idx], vs[idx] ? "R2" : "R4", "out_data bit-exact",
               longint'(od), ys[idx]);
         dif = real'(longint'(od)) - yrs[idx];
         check(dif <= 4.0 && dif >= -4.0, "R1", "distance to ideal recursion",
               longint'(od), longint'($rtoi(yrs[idx])));
      end
   endtask

   task automatic step(input bit v, input longint d);
      @(negedge clk);
      compare_out();
      iv = v;
      id = DW'(d);
      push_sample(v, d);
   endtask

   task automatic apply_reset(input int n);
      @(negedge clk);
      rst = 1'b1;
      iv  = 1'b0;
      id  = '0;
      repeat (n) begin
         @(negedge clk);
         check(ov == 1'b0, "R6", "out_valid in reset", longint'(ov), 0);
         check(od == '0, "R6", "out_data in reset", longint'(od), 0);
      end
      xs.delete();
      ys.delete();
      yrs.delete();
      vs.delete();
      rst = 1'b0;
      push_sample(1'b0, 0);   // the release cycle itself enters as an empty sample
   endtask

   initial begin
      apply_reset(4);
      repeat (20) step(1'b1, 0);                      // R6: zeros give zeros
      step(1'b1, 16384);                              // impulse
      repeat (60) step(1'b1, 0);
      repeat (250) step(1'b1, YMAX);                  // R5 positive full scale
      check(longint'(od) >= YMAX - 4, "R5", "settled positive full scale", longint'(od), YMAX);
      repeat (250) step(1'b1, YMIN);                  // R5 negative full scale
      check(longint'(od) <= YMIN + 4, "R5", "settled negative full scale", longint'(od), YMIN);
      repeat (600) begin                              // R4: gaps carry garbage data
         rnd = DW'($urandom);
         step(($urandom % 10) < 7, longint'(rnd));
      end
      for (int i = 0; i < 100; i++) step(1'b1, (i % 2) ? YMAX : YMIN);
      for (int i = 0; i < 200; i++) begin
         rnd = DW'($urandom);
         step((i % 5) == 0, longint'(rnd));
      end
      apply_reset(3);                                 // R6 mid-stream reset
      repeat (10) step(1'b1, 0);
      repeat (200) begin
         rnd = DW'($urandom);
         step(1'b1, longint'(rnd));
      end
      repeat (LAT + 2) step(1'b0, 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule